// File: doc/BRIEF.md
# Sign-Magnitude Converter Capture Sequencer

This block runs one conversion on an external converter that delivers an unsigned magnitude, and joins that magnitude with a polarity bit from a separate sign detector. A host asks for a measurement by raising a request while the block is idle. The sequencer then:

- sends a one-cycle start pulse to the converter;
- waits for the converter's completion pulse;
- turns on the converter's output drivers;
- switches the shared result buffer from counter use to voltmeter use;
- latches magnitude and polarity together into one result register.

The result is presented to the host as a sign-magnitude word with a valid flag. A programmable watchdog on the wait phase abandons a conversion that never completes and raises an error flag. The host reads the result once valid is high and sends its next request whenever it wants a new reading. The host sets the wait limit in clock cycles, and a limit of zero lets the block wait indefinitely.

Top module: `smadc_capture_top`

## Requirements
- R1: While reset is asserted, and after it is released, conv_start_o, conv_oe_o, buf_mode_o, busy_o, res_valid_o, err_o and res_mag_o are all 0; an asynchronous reset during a conversion returns the block to idle at once.
- R2: A request sampled high at a rising edge while idle makes conv_start_o high for exactly the following cycle; busy_o is high from that cycle until the sequence ends.
- R3: A completion pulse sampled during the wait phase raises conv_oe_o in the next cycle for exactly two cycles; a completion pulse while idle is ignored.
- R4: buf_mode_o is 1 (voltmeter use) exactly while conv_oe_o is high and 0 (counter use) otherwise.
- R5: At the second rising edge after the completion edge, res_mag_o takes adc_mag_i and res_sign_o takes adc_sign_i (1 = negative), and res_valid_o rises.
- R6: In the cycle that follows the capture, conv_oe_o and buf_mode_o are 0 and busy_o is 0.
- R7: The captured sign and magnitude stay unchanged and res_valid_o stays 1 until the next accepted request, which clears res_valid_o in the following cycle.
- R8: A request while busy_o is high produces no start pulse, either at once or after the sequence ends.
- R9: With tmo_limit_i = L > 0, if no completion pulse is seen in the first L cycles of the wait phase, the block goes idle with err_o = 1, res_valid_o = 0 and no driver enable; err_o clears in the cycle after the next accepted request.
- R10: With tmo_limit_i = 0 the wait phase has no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Host request for one measurement |
| tmo_limit_i | input | TMO_W | Wait-phase limit in cycles, 0 = unlimited |
| conv_end_i | input | 1 | Completion pulse from the converter |
| adc_mag_i | input | MAG_W | Magnitude from the converter's output drivers |
| adc_sign_i | input | 1 | Polarity from the sign detector, 1 = negative |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_oe_o | output | 1 | Converter output-driver enable |
| buf_mode_o | output | 1 | Result buffer use: 1 voltmeter, 0 counter |
| busy_o | output | 1 | A sequence is in progress |
| res_mag_o | output | MAG_W | Captured magnitude |
| res_sign_o | output | 1 | Captured polarity |
| res_valid_o | output | 1 | Captured result is valid |
| err_o | output | 1 | Last sequence ended by timeout |

## Verification
Every result has a fixed latency counted from the rising edge that samples the stimulus. The start pulse is seen one cycle after the request edge. Driver enable and voltmeter use appear one cycle after the completion edge, and the captured word and valid flag appear two cycles after it. The error flag appears right after the L-th sampled cycle of the wait phase. The bench drives and samples only on falling edges and steps through exactly those numbers of falling edges before each check, so every value is read at the first cycle it is due. Where a check states that something must not happen, the bench also looks at the cycles around that point.

// File: rtl/smadc_pkg.sv
package smadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_START   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_ENABLE  = 3'd3,
    ST_CAPTURE = 3'd4
  } seq_state_e;

  localparam logic BUF_MODE_COUNTER = 1'b0;
  localparam logic BUF_MODE_VOLT    = 1'b1;

endpackage

// File: rtl/smadc_rst_sync.sv
module smadc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/smadc_wait_timer.sv
module smadc_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] CNT_ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;
  logic             limit_on;

  assign limit_on = (limit_i != '0);
  assign cnt_en   = clear_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = tick_i && limit_on && (cnt_q == (limit_i - CNT_ONE));

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && limit_on) |-> (cnt_q < limit_i)) else $error("wait count beyond limit"); // R9

endmodule

// File: rtl/smadc_seq_fsm.sv
module smadc_seq_fsm
  import smadc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic conv_end_i,
  input  logic expire_i,
  output logic accept_o,
  output logic clear_o,
  output logic tick_o,
  output logic capture_o,
  output logic abort_o,
  output logic conv_start_o,
  output logic conv_oe_o,
  output logic buf_mode_o,
  output logic busy_o
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_START;
      ST_START:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_end_i)    state_d = ST_ENABLE;
        else if (expire_i) state_d = ST_IDLE;
      end
      ST_ENABLE:  state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept_o     = (state_q == ST_IDLE) && req_i;
  assign clear_o      = (state_q == ST_START);
  assign tick_o       = (state_q == ST_WAIT) && !conv_end_i;
  assign abort_o      = (state_q == ST_WAIT) && !conv_end_i && expire_i;
  assign capture_o    = (state_q == ST_CAPTURE);
  assign conv_start_o = (state_q == ST_START);
  assign conv_oe_o    = (state_q == ST_ENABLE) || (state_q == ST_CAPTURE);
  assign buf_mode_o   = conv_oe_o ? BUF_MODE_VOLT : BUF_MODE_COUNTER;
  assign busy_o       = (state_q != ST_IDLE);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o) else $error("start pulse too long"); // R2
  AST_OE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && conv_end_i) |=> conv_oe_o) else $error("driver enable late"); // R3
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !conv_start_o) else $error("start while busy"); // R8

endmodule

// File: rtl/smadc_result_reg.sv
module smadc_result_reg #(
  parameter int MAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             abort_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             sign_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             sign_o,
  output logic             valid_o,
  output logic             err_o
);

  logic [MAG_W-1:0] mag_q;
  logic             sign_q;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             flag_en;

  assign flag_en = clr_i | cap_i | abort_i;

  always_comb begin
    valid_d = valid_q;
    err_d   = err_q;
    if (clr_i) begin
      valid_d = 1'b0;
      err_d   = 1'b0;
    end else begin
      if (cap_i)   valid_d = 1'b1;
      if (abort_i) err_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else if (cap_i) begin
      mag_q  <= mag_i;
      sign_q <= sign_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (flag_en) begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign mag_o   = mag_q;
  assign sign_o  = sign_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> (valid_q && $stable(mag_q) && $stable(sign_q)))
    else $error("result moved while valid"); // R7
  AST_ERR_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q)) else $error("valid and error together"); // R9

endmodule

// File: rtl/smadc_capture_top.sv
module smadc_capture_top
  import smadc_pkg::*;
#(
  parameter int MAG_W       = 10,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             conv_end_i,
  input  logic [MAG_W-1:0] adc_mag_i,
  input  logic             adc_sign_i,
  output logic             conv_start_o,
  output logic             conv_oe_o,
  output logic             buf_mode_o,
  output logic             busy_o,
  output logic [MAG_W-1:0] res_mag_o,
  output logic             res_sign_o,
  output logic             res_valid_o,
  output logic             err_o
);

  logic rst_sync_n;
  logic accept, clear, tick, capture, abort, expire;

  smadc_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  smadc_seq_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_i        (req_i),
    .conv_end_i   (conv_end_i),
    .expire_i     (expire),
    .accept_o     (accept),
    .clear_o      (clear),
    .tick_o       (tick),
    .capture_o    (capture),
    .abort_o      (abort),
    .conv_start_o (conv_start_o),
    .conv_oe_o    (conv_oe_o),
    .buf_mode_o   (buf_mode_o),
    .busy_o       (busy_o)
  );

  smadc_wait_timer #(.TMO_W(TMO_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear_i  (clear),
    .tick_i   (tick),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  smadc_result_reg #(.MAG_W(MAG_W)) result_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (accept),
    .cap_i   (capture),
    .abort_i (abort),
    .mag_i   (adc_mag_i),
    .sign_i  (adc_sign_i),
    .mag_o   (res_mag_o),
    .sign_o  (res_sign_o),
    .valid_o (res_valid_o),
    .err_o   (err_o)
  );

  AST_MODE_DURING_OE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_oe_o |-> (buf_mode_o == BUF_MODE_VOLT)) else $error("buffer not in voltmeter use"); // R4
  AST_CAPTURE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    capture |-> (conv_oe_o && buf_mode_o == BUF_MODE_VOLT)) else $error("capture outside window"); // R5
  AST_OE_DROP_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(res_valid_o) |-> (!conv_oe_o && !busy_o)) else $error("drivers held after capture"); // R6

endmodule

// File: tb/smadc_capture_top_tb_top.sv
`timescale 1ns/1ps
module smadc_capture_top_tb_top;

  localparam int MAG_W = 10;
  localparam int TMO_W = 16;
  localparam int NV    = 7;
  // fields: delay[35:28] mag[27:18] sign[17] limit[16:1] err[0]
  localparam logic [35:0] VEC [NV] = '{
    {8'd0,  10'h155, 1'b0, 16'd16, 1'b0},
    {8'd5,  10'h3FF, 1'b1, 16'd16, 1'b0},
    {8'd15, 10'h000, 1'b1, 16'd16, 1'b0},
    {8'd0,  10'h0AA, 1'b0, 16'd4,  1'b1},
    {8'd3,  10'h2AA, 1'b0, 16'd0,  1'b0},
    {8'd40, 10'h001, 1'b1, 16'd0,  1'b0},
    {8'd0,  10'h123, 1'b0, 16'd1,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [TMO_W-1:0] tmo_limit;
  logic conv_end;
  logic [MAG_W-1:0] adc_mag;
  logic adc_sign;
  logic conv_start, conv_oe, buf_mode, busy, res_sign, res_valid, err;
  logic [MAG_W-1:0] res_mag;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  smadc_capture_top #(.MAG_W(MAG_W), .TMO_W(TMO_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .tmo_limit_i  (tmo_limit),
    .conv_end_i   (conv_end),
    .adc_mag_i    (adc_mag),
    .adc_sign_i   (adc_sign),
    .conv_start_o (conv_start),
    .conv_oe_o    (conv_oe),
    .buf_mode_o   (buf_mode),
    .busy_o       (busy),
    .res_mag_o    (res_mag),
    .res_sign_o   (res_sign),
    .res_valid_o  (res_valid),
    .err_o        (err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int d, input logic [MAG_W-1:0] mag, input logic sgn,
                         input logic [TMO_W-1:0] lim, input logic exp_err);
    tmo_limit = lim;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R2 start pulse", conv_start, 1);
    chk("R2 busy", busy, 1);
    chk("R7 valid cleared by request", res_valid, 0);
    chk("R9 err cleared by request", err, 0);
    @(negedge clk);
    chk("R2 start width", conv_start, 0);
    if (exp_err) begin
      repeat (int'(lim)) @(negedge clk);
      chk("R9 err raised", err, 1);
      chk("R9 valid low", res_valid, 0);
      chk("R9 idle after timeout", busy, 0);
      chk("R9 no drivers", conv_oe, 0);
    end else begin
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk("R10 still waiting", busy, 1);
        chk("R3 drivers off while waiting", conv_oe, 0);
      end
      conv_end = 1'b1;
      adc_mag  = ~mag;
      adc_sign = ~sgn;
      @(negedge clk);
      conv_end = 1'b0;
      chk("R3 drivers on", conv_oe, 1);
      chk("R4 voltmeter use", buf_mode, 1);
      chk("R5 not yet valid", res_valid, 0);
      adc_mag  = mag;
      adc_sign = sgn;
      @(negedge clk);
      chk("R3 drivers second cycle", conv_oe, 1);
      chk("R4 voltmeter use second cycle", buf_mode, 1);
      @(negedge clk);
      chk("R5 valid", res_valid, 1);
      chk("R5 magnitude", res_mag, mag);
      chk("R5 sign", res_sign, sgn);
      chk("R6 drivers released", conv_oe, 0);
      chk("R6 counter use", buf_mode, 0);
      chk("R6 idle", busy, 0);
      adc_mag  = ~mag;
      adc_sign = ~sgn;
    end
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; tmo_limit = '0; conv_end = 1'b0;
    adc_mag = '0; adc_sign = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", conv_start, 0);
    chk("R1 oe in reset", conv_oe, 0);
    chk("R1 mode in reset", buf_mode, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", res_valid, 0);
    chk("R1 err in reset", err, 0);
    chk("R1 mag in reset", res_mag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", busy, 0);

    // completion pulse while idle is ignored
    conv_end = 1'b1;
    @(negedge clk);
    conv_end = 1'b0;
    chk("R3 idle end ignored oe", conv_oe, 0);
    chk("R3 idle end ignored busy", busy, 0);
    @(negedge clk);
    chk("R3 idle end ignored valid", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(int'(VEC[i][35:28]), VEC[i][27:18], VEC[i][17], VEC[i][16:1], VEC[i][0]);
      repeat (2) @(negedge clk);
    end

    // result held while inputs move
    run_vec(2, 10'h2C3, 1'b1, 16'd8, 1'b0);
    for (int k = 0; k < 5; k++) begin
      adc_mag  = 10'(k * 77);
      adc_sign = k[0];
      @(negedge clk);
      chk("R7 valid held", res_valid, 1);
      chk("R7 magnitude held", res_mag, 10'h2C3);
      chk("R7 sign held", res_sign, 1);
    end

    // requests while busy are ignored
    tmo_limit = 16'd20;
    req = 1'b1;
    @(negedge clk);
    chk("R2 start pulse for busy test", conv_start, 1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no start while busy", conv_start, 0);
    end
    conv_end = 1'b1;
    adc_mag = 10'h0F0;
    adc_sign = 1'b0;
    @(negedge clk);
    conv_end = 1'b0;
    chk("R8 no start in enable", conv_start, 0);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk("R8 single result", res_mag, 10'h0F0);
    chk("R8 idle after sequence", busy, 0);
    @(negedge clk);
    chk("R8 no queued start", conv_start, 0);
    chk("R8 still idle", busy, 0);

    // asynchronous reset during a conversion
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset busy", busy, 0);
    chk("R1 mid reset valid", res_valid, 0);
    chk("R1 mid reset start", conv_start, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after mid reset", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule